// File: doc/BRIEF.md
# Multi-Ring Transfer Arbiter

This block decides which data transfers may use an on-chip interconnect made of several unidirectional rings. Twelve ports sit around the rings. Two of the four rings turn clockwise and two turn counter-clockwise. A port asks to move a number of 16-byte beats to another port. The arbiter picks the shorter direction and then a ring that turns that way. A ring can carry several transfers at once, provided the ring segments they cross do not overlap. Each granted transfer keeps its segments, and its source and destination ports, for as many cycles as it has beats.

A requester holds its request until it sees a one-cycle grant pulse. The pulse carries the index of the chosen ring. Selection works in two round-robin stages. The first stage chooses among requesters. The second stage chooses between the two rings of the selected direction.

Top module: `ring_xfer_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, no grant is given and every ring, segment and port is idle.
- R2: A port raises `req_valid[p]` and holds it until granted. A grant pulse `gnt[p]` appears one cycle after the clock edge at which the request was accepted. It lasts one cycle, is never given to a port that is not requesting, and is never given to the same port on two successive cycles.
- R3: Let h = (destination − source) mod 12. If h is 1 to 6, the transfer goes clockwise on ring 0 or 1. If h is 7 to 11, it goes counter-clockwise on ring 2 or 3. The ring index is `gnt_ring[2p+1:2p]`.
- R4: Segment k joins port k to port k+1 (mod 12). A clockwise transfer uses segments src … dst−1. A counter-clockwise transfer uses segments dst … src−1. No two live transfers on the same ring share a segment.
- R5: A transfer of b beats granted at edge n holds its segments, its source and its destination up to edge n+b. A conflicting request can be granted at edge n+b at the earliest. When nothing else blocks it, it is granted at exactly that edge.
- R6: Requests in the same direction whose segments do not overlap are granted in the same cycle, and two or more of them may share one ring.
- R7: No ring carries more than three live transfers. Further requests that could use only a full ring wait until a transfer on it finishes.
- R8: A port sends at most one live transfer and receives at most one live transfer at any time. Sending and receiving at the same time is allowed.
- R9: A request is never granted, and does not block other requests, if its destination equals its source, its destination is 12 or more, or its beat count is zero.
- R10: Requesters are scanned in round-robin order, starting at a pointer that is 0 after reset. After each cycle with grants, the pointer moves to the port just after the last winner in scan order.
- R11: Within each direction, a ring pointer (0 after reset) picks which ring is tried first. After each grant in that direction, the pointer moves to the ring after the one used.
- R12: Each request field is 4 bits per port: `req_dst[4p+3:4p]` and `req_beats[4p+3:4p]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 12 | Per-port request, held until granted |
| req_dst | input | 48 | Per-port destination index, 4 bits each |
| req_beats | input | 48 | Per-port beat count, 4 bits each |
| gnt | output | 12 | Per-port one-cycle grant pulse |
| gnt_ring | output | 24 | Per-port ring index of the grant, 2 bits each |

## Verification
The assertions rely on two things from the requesters. A requester keeps its destination and beat count stable while its request is raised. It also drops the request in the cycle it sees its grant. Otherwise the destination-based checks, which use the fields sampled one edge before the pulse, would compare against the wrong transfer. The bench's random stimulus picks a valid destination and a beat count from 1 to 8 only when a port is idle. It leaves those fields untouched until the grant arrives and clears the request at the sampling point right after the pulse. Invalid fields appear only in a directed case.

// File: rtl/ring_xfer_arbiter.sv
module ring_xfer_arbiter #(
  parameter int NPORT = 12,
  parameter int NRING = 4,
  parameter int SLOTS = 3,
  parameter int BW    = 4,
  parameter int DW    = $clog2(NPORT),
  parameter int RW    = $clog2(NRING)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPORT-1:0]    req_valid,
  input  logic [NPORT*DW-1:0] req_dst,
  input  logic [NPORT*BW-1:0] req_beats,
  output logic [NPORT-1:0]    gnt,
  output logic [NPORT*RW-1:0] gnt_ring
);
  localparam int HALF  = NRING / 2;
  localparam int HW    = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int REACH = NPORT / 2;

  logic [NPORT-1:0][DW-1:0] dst;
  logic [NPORT-1:0][BW-1:0] beats;
  assign dst   = req_dst;
  assign beats = req_beats;

  logic [NPORT-1:0] seg_q [NRING][SLOTS];
  logic [BW-1:0]    cnt_q [NRING][SLOTS];
  logic [BW-1:0]    tx_q  [NPORT];
  logic [BW-1:0]    rx_q  [NPORT];
  logic [DW-1:0]    ptr_q, ptr_d;
  logic [HW-1:0]    rptr_q [2];
  logic [HW-1:0]    rptr_d [2];
  logic [NPORT-1:0] gnt_q, gnt_d;
  logic [NPORT-1:0][RW-1:0] ring_q, ring_d;

  logic             ld     [NRING][SLOTS];
  logic [NPORT-1:0] ld_seg [NRING][SLOTS];
  logic [BW-1:0]    ld_cnt [NRING][SLOTS];
  logic [NPORT-1:0] rx_ld;
  logic [BW-1:0]    rx_val [NPORT];

  logic [NPORT-1:0] busy [NRING];
  logic             live [NRING][SLOTS];
  logic [NPORT-1:0] rx_busy;
  logic [NPORT-1:0] mask;
  logic             cw, done;
  int               p, d, h, r, dir, len, base;

  always_comb begin
    ptr_d  = ptr_q;
    rptr_d = rptr_q;
    gnt_d  = '0;
    ring_d = '0;
    rx_ld  = '0;
    mask   = '0;
    cw = 1'b0; done = 1'b0;
    p = 0; d = 0; h = 0; r = 0; dir = 0; len = 0; base = 0;
    for (int i = 0; i < NPORT; i++) begin
      rx_val[i]  = '0;
      rx_busy[i] = (rx_q[i] != '0);
    end
    for (int i = 0; i < NRING; i++) begin
      busy[i] = '0;
      for (int s = 0; s < SLOTS; s++) begin
        live[i][s]   = (cnt_q[i][s] != '0);
        ld[i][s]     = 1'b0;
        ld_seg[i][s] = '0;
        ld_cnt[i][s] = '0;
        if (live[i][s]) busy[i] = busy[i] | seg_q[i][s];
      end
    end
    for (int k = 0; k < NPORT; k++) begin
      p = (int'(ptr_q) + k) % NPORT;
      d = int'(dst[p]);
      if (req_valid[p] && !gnt_q[p] && d < NPORT && d != p && beats[p] != '0 &&
          tx_q[p] == '0 && !rx_busy[d % NPORT]) begin
        h    = (d - p + NPORT) % NPORT;
        cw   = (h <= REACH);
        dir  = cw ? 0 : 1;
        len  = cw ? h : NPORT - h;
        base = cw ? p : d;
        mask = '0;
        for (int i = 0; i < NPORT; i++)
          if (i < len) mask[(base + i) % NPORT] = 1'b1;
        done = 1'b0;
        for (int j = 0; j < HALF; j++) begin
          r = dir * HALF + (int'(rptr_d[dir]) + j) % HALF;
          if (!done && (busy[r] & mask) == '0) begin
            for (int s = 0; s < SLOTS; s++) begin
              if (!done && !live[r][s]) begin
                done         = 1'b1;
                live[r][s]   = 1'b1;
                busy[r]      = busy[r] | mask;
                ld[r][s]     = 1'b1;
                ld_seg[r][s] = mask;
                ld_cnt[r][s] = beats[p] - BW'(1);
                gnt_d[p]     = 1'b1;
                ring_d[p]    = RW'(r);
                rptr_d[dir]  = HW'((int'(rptr_d[dir]) + j + 1) % HALF);
                rx_busy[d % NPORT] = 1'b1;
                rx_ld[d % NPORT]   = 1'b1;
                rx_val[d % NPORT]  = beats[p] - BW'(1);
                ptr_d = DW'((p + 1) % NPORT);
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      gnt_q  <= '0;
      ring_q <= '0;
      for (int i = 0; i < 2; i++) rptr_q[i] <= '0;
      for (int i = 0; i < NPORT; i++) begin
        tx_q[i] <= '0;
        rx_q[i] <= '0;
      end
      for (int i = 0; i < NRING; i++)
        for (int s = 0; s < SLOTS; s++) begin
          seg_q[i][s] <= '0;
          cnt_q[i][s] <= '0;
        end
    end else begin
      ptr_q  <= ptr_d;
      gnt_q  <= gnt_d;
      ring_q <= ring_d;
      for (int i = 0; i < 2; i++) rptr_q[i] <= rptr_d[i];
      for (int i = 0; i < NPORT; i++) begin
        if (gnt_d[i])          tx_q[i] <= beats[i] - BW'(1);
        else if (tx_q[i] != 0) tx_q[i] <= tx_q[i] - BW'(1);
        if (rx_ld[i])          rx_q[i] <= rx_val[i];
        else if (rx_q[i] != 0) rx_q[i] <= rx_q[i] - BW'(1);
      end
      for (int i = 0; i < NRING; i++)
        for (int s = 0; s < SLOTS; s++)
          if (ld[i][s]) begin
            seg_q[i][s] <= ld_seg[i][s];
            cnt_q[i][s] <= ld_cnt[i][s];
          end else if (cnt_q[i][s] != 0) begin
            cnt_q[i][s] <= cnt_q[i][s] - BW'(1);
          end
    end
  end

  assign gnt      = gnt_q;
  assign gnt_ring = ring_q;
endmodule

// File: rtl/ring_xfer_arbiter_chk.sv
module ring_xfer_arbiter_chk #(
  parameter int NPORT = 12,
  parameter int NRING = 4,
  parameter int BW    = 4,
  parameter int DW    = $clog2(NPORT),
  parameter int RW    = $clog2(NRING)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NPORT-1:0]    req_valid,
  input logic [NPORT*DW-1:0] req_dst,
  input logic [NPORT*BW-1:0] req_beats,
  input logic [NPORT-1:0]    gnt,
  input logic [NPORT*RW-1:0] gnt_ring
);
  localparam int HALF = NRING / 2;

  logic [NPORT-1:0][DW-1:0] dst_q;
  logic [NPORT-1:0][BW-1:0] beats_q;
  always_ff @(posedge clk) begin
    dst_q   <= req_dst;
    beats_q <= req_beats;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[p] |-> $past(req_valid[p]));
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[p] |=> !gnt[p]);
    assert_valid_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[p] |-> (int'(dst_q[p]) != p && int'(dst_q[p]) < NPORT && beats_q[p] != '0));
    assert_short_way_R3: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[p] |-> ((int'(gnt_ring[p*RW +: RW]) < HALF) ==
                  (((int'(dst_q[p]) - p + NPORT) % NPORT) <= NPORT / 2)));
  end

  for (genvar d = 0; d < NPORT; d++) begin : g_dst
    logic [NPORT-1:0] hit;
    always_comb
      for (int p = 0; p < NPORT; p++) hit[p] = gnt[p] && int'(dst_q[p]) == d;
    assert_one_receiver_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit) <= 1);
  end
endmodule

bind ring_xfer_arbiter ring_xfer_arbiter_chk #(
  .NPORT(NPORT), .NRING(NRING), .BW(BW), .DW(DW), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst(req_dst),
  .req_beats(req_beats), .gnt(gnt), .gnt_ring(gnt_ring)
);

// File: tb/sim_ring_xfer_arbiter.sv
module sim_ring_xfer_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12, NR = 4, DW = 4, BW = 4, RW = 2, HALF = 2, NSLOT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] rv = '0;
  logic [N-1:0][DW-1:0] rd = '0;
  logic [N-1:0][BW-1:0] rb = '0;
  logic [N-1:0] gnt;
  logic [N*RW-1:0] gr;

  ring_xfer_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_dst(rd), .req_beats(rb),
    .gnt(gnt), .gnt_ring(gr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, ncyc = 0, grants_now = 0;
  int seg_until [NR][N];
  int slot_until [NR][NSLOT];
  int tx_until [N];
  int rx_until [N];
  int gcyc [N];
  int gring [N];
  int wait_age [N];
  int ring_now [NR];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_cw(input int s, input int d);
    return ((d - s + N) % N) <= N / 2;
  endfunction

  function automatic logic [N-1:0] seg_set(input int s, input int d);
    logic [N-1:0] m = '0;
    int h = (d - s + N) % N;
    int len = is_cw(s, d) ? h : N - h;
    int base = is_cw(s, d) ? s : d;
    for (int i = 0; i < len; i++) m[(base + i) % N] = 1'b1;
    return m;
  endfunction

  task automatic model_grant(input int p);
    int d, b, r, live, conflict;
    logic [N-1:0] m;
    if (!rv[p]) begin
      check(0, "R2 grant to idle port", p, -1);
      return;
    end
    d = int'(rd[p]); b = int'(rb[p]); r = int'(gr[p*RW +: RW]);
    check(d < N && d != p && b != 0, "R9 invalid request granted", p, -1);
    if (d < N && d != p && b != 0) begin
      check((r < HALF) == is_cw(p, d), "R3 ring direction", r, is_cw(p, d) ? 0 : HALF);
      m = seg_set(p, d);
      conflict = 0;
      for (int i = 0; i < N; i++) if (m[i] && seg_until[r][i] > ncyc) conflict++;
      check(conflict == 0, "R4 segment overlap", conflict, 0);
      live = 0;
      for (int s = 0; s < NSLOT; s++) if (slot_until[r][s] > ncyc) live++;
      check(live < NSLOT, "R7 ring occupancy", live + 1, NSLOT);
      for (int s = 0; s < NSLOT; s++)
        if (slot_until[r][s] <= ncyc) begin
          slot_until[r][s] = ncyc + b;
          break;
        end
      check(tx_until[p] <= ncyc, "R8 source busy", tx_until[p], ncyc);
      check(rx_until[d] <= ncyc, "R8 destination busy", rx_until[d], ncyc);
      for (int i = 0; i < N; i++) if (m[i]) seg_until[r][i] = ncyc + b;
      tx_until[p] = ncyc + b;
      rx_until[d] = ncyc + b;
    end
    ring_now[r]++;
    gcyc[p] = ncyc; gring[p] = r; rv[p] = 1'b0; wait_age[p] = 0;
  endtask

  task automatic step();
    @(negedge clk);
    ncyc++;
    grants_now = 0;
    for (int r = 0; r < NR; r++) ring_now[r] = 0;
    for (int p = 0; p < N; p++) begin
      if (gnt[p]) begin
        grants_now++;
        model_grant(p);
      end else if (rv[p]) begin
        wait_age[p]++;
        if (wait_age[p] == 600) check(0, "R10 starvation", wait_age[p], 0);
      end
    end
  endtask

  task automatic req(input int p, input int d, input int b);
    rv[p] = 1'b1; rd[p] = DW'(d); rb[p] = BW'(b); wait_age[p] = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rv = '0; rd = '0; rb = '0;
    for (int r = 0; r < NR; r++) begin
      for (int i = 0; i < N; i++) seg_until[r][i] = 0;
      for (int s = 0; s < NSLOT; s++) slot_until[r][s] = 0;
    end
    for (int i = 0; i < N; i++) begin
      tx_until[i] = 0; rx_until[i] = 0; gcyc[i] = -1; gring[i] = -1; wait_age[i] = 0;
    end
    step(); step();
    rst_n = 1'b1;
    step();
    check(gnt == '0, "R1 idle after reset", int'(gnt), 0);
  endtask

  task automatic wait_for(input int p, input int lim, output int n);
    n = 0;
    while (gcyc[p] != ncyc && n < lim) begin
      step();
      n++;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int n, tot;
    void'($urandom(32'h1d5e_0c07));

    do_reset();
    repeat (3) begin
      step();
      check(grants_now == 0, "R1 no grant without request", grants_now, 0);
    end

    // R3 / R11: direction and ring preference
    do_reset();
    req(0, 3, 4); step();
    check(gcyc[0] == ncyc && gring[0] == 0, "R11 first clockwise on ring 0", gring[0], 0);
    req(4, 1, 2); step();
    check(gcyc[4] == ncyc && gring[4] == 2, "R3 counter-clockwise ring 2", gring[4], 2);
    req(1, 2, 1); step();
    check(gcyc[1] == ncyc && gring[1] == 1, "R11 next clockwise on ring 1", gring[1], 1);
    req(6, 0, 1); step();
    check(gcyc[6] == ncyc && gring[6] == 0, "R3 six hops go clockwise", gring[6], 0);

    // R5 / R8: destination and source held for the beat count
    do_reset();
    req(2, 5, 3); step();
    check(gcyc[2] == ncyc, "R2 grant one cycle later", gcyc[2], ncyc);
    req(3, 5, 3); req(2, 8, 1);
    wait_for(3, 20, n);
    check(n == 3, "R5 R8 destination reuse delay", n, 3);
    check(gcyc[2] == gcyc[3], "R8 source reuse delay", gcyc[2], gcyc[3]);

    // R4 / R5: overlapping clockwise transfers
    do_reset();
    req(0, 4, 5); req(1, 5, 5); req(2, 6, 5); step();
    check(grants_now == 2 && ring_now[0] == 1 && ring_now[1] == 1,
          "R4 two overlapping fit on two rings", grants_now, 2);
    wait_for(2, 30, n);
    check(n == 5, "R5 segment release after beats", n, 5);

    // R6 / R7: spatial reuse and ring capacity
    do_reset();
    for (int p = 0; p < N; p++) req(p, (p + 1) % N, 4);
    step();
    check(grants_now == 6, "R6 disjoint granted together", grants_now, 6);
    check(ring_now[0] == 3 && ring_now[1] == 3, "R7 three per ring", ring_now[0], 3);
    tot = 0;
    repeat (3) begin step(); tot += grants_now; end
    check(tot == 0, "R7 full rings wait", tot, 0);
    step();
    check(grants_now == 6, "R7 rest granted on release", grants_now, 6);

    // R9: invalid requests ignored
    do_reset();
    req(5, 5, 2); req(6, 7, 0); req(7, 13, 1); req(8, 9, 1);
    step();
    check(grants_now == 1 && gcyc[8] == ncyc, "R9 valid neighbour granted", grants_now, 1);
    tot = 0;
    repeat (10) begin step(); tot += grants_now; end
    check(tot == 0 && rv[5] && rv[6] && rv[7], "R9 invalid never granted", tot, 0);

    // R10: round robin among requesters to one destination
    do_reset();
    req(0, 5, 1); req(1, 5, 1); req(2, 5, 1);
    step();
    check(gcyc[0] == ncyc, "R10 order first winner port 0", gcyc[0], ncyc);
    req(0, 5, 1);
    step();
    check(gcyc[1] == ncyc, "R10 order second winner port 1", gcyc[1], ncyc);
    step();
    check(gcyc[2] == ncyc, "R10 pointer passes port 0 to port 2", gcyc[2], ncyc);
    step();
    check(gcyc[0] == ncyc, "R10 port 0 served last", gcyc[0], ncyc);

    // R12 and everything else under constrained random traffic
    do_reset();
    for (int c = 0; c < 4000; c++) begin
      step();
      for (int p = 0; p < N; p++)
        if (!rv[p] && ($urandom % 4) == 0)
          req(p, (p + 1 + int'($urandom % (N - 1))) % N, 1 + int'($urandom % 8));
    end
    repeat (300) step();
    check(rv == '0, "R10 R12 all random requests served", int'(rv), 0);

    summary();
    $finish;
  end
endmodule